// File: doc/BRIEF.md
# Page Access Beat Timer

This block paces the data beats of a multiple-access cycle toward an external memory. Examples are a page read with asynchronous timing and a synchronous burst. A cycle is launched with three settings: a per-beat access time in functional clock cycles, the number of beats, and a 2-bit clock divider setting. The block then marks the end of each beat with a one-cycle strobe. It flags the final beat of the cycle alongside that strobe.

A beat ends only when two conditions hold together. The programmed access time must have run out, and the external active-low wait line must be released. Wait is honoured on every beat of the cycle, not only on the first one. The wait line passes through a two-flop synchronizer before use.

While a cycle runs, the block also produces an external clock enable at the functional clock divided by (divider + 1). A launch is refused, and a configuration-error flag is raised, if any of these holds:
- the access time is not a nonzero multiple of that period;
- the beat count is zero.

Top module: `page_beat_timer`

## Requirements
- R1: After reset, busy_o, beat_done_o, last_beat_o, ext_clk_en_o and cfg_err_o are all low.
- R2: A start_i pulse while idle, with acc_cycles_i a nonzero multiple of (div_sel_i + 1) and beat_num_i nonzero, makes busy_o high from the next cycle. That start also clears cfg_err_o.
- R3: A start_i pulse while idle is rejected in any of these cases:
  - acc_cycles_i is zero;
  - acc_cycles_i is not a multiple of (div_sel_i + 1);
  - beat_num_i is zero.
  A rejected start sets cfg_err_o on the next cycle and leaves busy_o low. cfg_err_o stays set until an accepted start.
- R4: With wait released, beat_done_o pulses once every acc_cycles_i cycles. The first pulse comes acc_cycles_i cycles after busy_o rises.
- R5: beat_done_o is asserted only when the access time of the current beat has expired and the synchronized wait is released. An asserted wait (wait_n_i low) holds the beat indefinitely.
- R6: wait_n_i reaches the beat logic through two flip-flops. A release of wait_n_i can complete an expired beat no earlier than two clock edges later.
- R7: Wait is monitored on every beat of a cycle, including beats after the first.
- R8: last_beat_o is high together with the beat_done_o of beat number beat_num_i. busy_o is low on the following cycle.
- R9: ext_clk_en_o pulses on the first busy cycle and then every (div_sel_i + 1) cycles while busy_o is high. It is never high while idle.
- R10: start_i and the configuration inputs are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse for a multiple-access cycle |
| div_sel_i | input | 2 | Clock divider setting; period is value + 1 |
| acc_cycles_i | input | ACC_W | Per-beat access time in functional cycles |
| beat_num_i | input | BEAT_W | Number of beats in the cycle |
| wait_n_i | input | 1 | External wait, low means the memory is not ready |
| busy_o | output | 1 | A cycle is in progress |
| ext_clk_en_o | output | 1 | External clock enable pulse |
| beat_done_o | output | 1 | One-cycle beat-complete strobe |
| last_beat_o | output | 1 | Marks the strobe of the final beat |
| cfg_err_o | output | 1 | Last launch attempt was rejected |

## Verification
The assertions check, on every cycle, several local rules:
- a strobe never appears without a released synchronized wait;
- a held wait freezes the beat index;
- the last-beat mark implies a strobe and ends the cycle;
- clock-enable pulses stay inside busy, with the first busy cycle carrying one;
- accepted and rejected launches move busy and the error flag as required.

Other behaviours are properties of whole sequences, and only the bench's scenarios can show them:
- the exact spacing of strobes for each access time;
- the two-edge latency of a wait release;
- wait stalls on later beats;
- the beat count of a cycle hit by a launch attempt in mid-cycle;
- the enable spacing for every divider setting.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  localparam int DIV_W = 2;

  typedef enum logic {
    PBT_IDLE = 1'b0,
    PBT_RUN  = 1'b1
  } pbt_state_e;

  // External clock period in functional cycles for a divider setting
  function automatic logic [DIV_W:0] pbt_period(input logic [DIV_W-1:0] div);
    return {1'b0, div} + (DIV_W+1)'(1);
  endfunction

  // Next phase of the external clock divider
  function automatic logic [DIV_W-1:0] pbt_phase_next(input logic [DIV_W-1:0] ph,
                                                     input logic [DIV_W-1:0] div);
    return (ph == div) ? '0 : ph + DIV_W'(1);
  endfunction

endpackage

// File: rtl/pbt_wait_sync.sv
module pbt_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pbt_cfg_check.sv
module pbt_cfg_check
  import pbt_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int BEAT_W = 5
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              cfg_ok
);

  logic [ACC_W-1:0] period;
  logic [ACC_W-1:0] remainder;

  assign period    = ACC_W'(pbt_period(div_i));
  assign remainder = acc_i % period;
  assign cfg_ok    = (acc_i != '0) && (beats_i != '0) && (remainder == '0);

endmodule

// File: rtl/pbt_clk_div.sv
module pbt_clk_div
  import pbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= pbt_phase_next(phase, div_q);
  end

  assign tick = run && (phase == '0);

endmodule

// File: rtl/pbt_beat_ctrl.sv
module pbt_beat_ctrl
  import pbt_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_ok,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wait_ok,
  output logic              busy,
  output logic              beat_done,
  output logic              last_beat,
  output logic              cfg_err,
  output logic [DIV_W-1:0]  div_q,
  output logic              timer_zero,
  output logic [BEAT_W-1:0] beat_idx
);

  pbt_state_e        state;
  logic [ACC_W-1:0]  timer;
  logic [ACC_W-1:0]  acc_q;
  logic [BEAT_W-1:0] beats_q;
  logic              final_beat;

  assign busy       = (state == PBT_RUN);
  assign timer_zero = (timer == '0);
  assign final_beat = (beat_idx == beats_q - BEAT_W'(1));
  assign beat_done  = busy && timer_zero && wait_ok;
  assign last_beat  = beat_done && final_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PBT_IDLE;
      timer    <= '0;
      acc_q    <= '0;
      beats_q  <= '0;
      div_q    <= '0;
      beat_idx <= '0;
      cfg_err  <= 1'b0;
    end else begin
      case (state)
        PBT_IDLE: begin
          if (start) begin
            if (cfg_ok) begin
              state    <= PBT_RUN;
              timer    <= acc_i - ACC_W'(1);
              acc_q    <= acc_i;
              beats_q  <= beats_i;
              div_q    <= div_i;
              beat_idx <= '0;
              cfg_err  <= 1'b0;
            end else begin
              cfg_err  <= 1'b1;
            end
          end
        end
        PBT_RUN: begin
          if (beat_done) begin
            if (final_beat) begin
              state <= PBT_IDLE;
            end else begin
              timer    <= acc_q - ACC_W'(1);
              beat_idx <= beat_idx + BEAT_W'(1);
            end
          end else if (!timer_zero) begin
            timer <= timer - ACC_W'(1);
          end
        end
        default: state <= PBT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_beat_timer.sv
module page_beat_timer
  import pbt_pkg::*;
#(
  parameter int ACC_W       = 8,
  parameter int BEAT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        div_sel_i,
  input  logic [ACC_W-1:0]  acc_cycles_i,
  input  logic [BEAT_W-1:0] beat_num_i,
  input  logic              wait_n_i,
  output logic              busy_o,
  output logic              ext_clk_en_o,
  output logic              beat_done_o,
  output logic              last_beat_o,
  output logic              cfg_err_o
);

  logic              wait_ok;
  logic              cfg_ok;
  logic              busy;
  logic              beat_done;
  logic              last_beat;
  logic              cfg_err;
  logic              clk_en;
  logic              timer_zero;
  logic [DIV_W-1:0]  div_q;
  logic [BEAT_W-1:0] beat_idx;

  pbt_wait_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (wait_n_i),
    .dout  (wait_ok)
  );

  pbt_cfg_check #(.ACC_W(ACC_W), .BEAT_W(BEAT_W)) u_cfg_check (
    .acc_i   (acc_cycles_i),
    .beats_i (beat_num_i),
    .div_i   (div_sel_i),
    .cfg_ok  (cfg_ok)
  );

  pbt_beat_ctrl #(.ACC_W(ACC_W), .BEAT_W(BEAT_W)) u_beat_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .cfg_ok     (cfg_ok),
    .acc_i      (acc_cycles_i),
    .beats_i    (beat_num_i),
    .div_i      (div_sel_i),
    .wait_ok    (wait_ok),
    .busy       (busy),
    .beat_done  (beat_done),
    .last_beat  (last_beat),
    .cfg_err    (cfg_err),
    .div_q      (div_q),
    .timer_zero (timer_zero),
    .beat_idx   (beat_idx)
  );

  pbt_clk_div u_clk_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div_q (div_q),
    .tick  (clk_en)
  );

  assign busy_o       = busy;
  assign ext_clk_en_o = clk_en;
  assign beat_done_o  = beat_done;
  assign last_beat_o  = last_beat;
  assign cfg_err_o    = cfg_err;

endmodule

// File: rtl/pbt_checker.sv
module pbt_checker #(
  parameter int BEAT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cfg_ok,
  input logic              busy,
  input logic              beat_done,
  input logic              last_beat,
  input logic              clk_en,
  input logic              cfg_err,
  input logic              wait_ok,
  input logic              timer_zero,
  input logic [BEAT_W-1:0] beat_idx
);

  p_start_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && cfg_ok) |=> busy);

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && !cfg_ok) |=> (cfg_err && !busy));

  p_done_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> wait_ok);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timer_zero && !wait_ok) |=> (busy && $stable(beat_idx)));

  p_last_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_done);

  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !busy);

  p_clken_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> busy);

  p_first_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> clk_en);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !beat_done) |=> busy);

endmodule

bind page_beat_timer pbt_checker #(.BEAT_W(BEAT_W)) u_pbt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .cfg_ok     (cfg_ok),
  .busy       (busy),
  .beat_done  (beat_done),
  .last_beat  (last_beat),
  .clk_en     (clk_en),
  .cfg_err    (cfg_err),
  .wait_ok    (wait_ok),
  .timer_zero (timer_zero),
  .beat_idx   (beat_idx)
);

// File: tb/test_page_beat_timer.sv
module test_page_beat_timer;

  localparam int ACC_W  = 8;
  localparam int BEAT_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        div_sel_i = '0;
  logic [ACC_W-1:0]  acc_cycles_i = '0;
  logic [BEAT_W-1:0] beat_num_i = '0;
  logic              wait_n_i = 1'b1;
  logic              busy_o, ext_clk_en_o, beat_done_o, last_beat_o, cfg_err_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  page_beat_timer #(.ACC_W(ACC_W), .BEAT_W(BEAT_W)) i_page_beat_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_sel_i(div_sel_i),
    .acc_cycles_i(acc_cycles_i), .beat_num_i(beat_num_i), .wait_n_i(wait_n_i),
    .busy_o(busy_o), .ext_clk_en_o(ext_clk_en_o), .beat_done_o(beat_done_o),
    .last_beat_o(last_beat_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Reference model: elapsed-cycle count per beat, wait history queue
  bit m_busy = 0, m_err = 0;
  int m_elapsed = 0, m_beat = 0, m_acc = 0, m_beats = 0, m_div = 0, m_ph = 0;
  bit wait_hist[$] = '{1'b1, 1'b1};

  function automatic bit m_done_f();
    return m_busy && (m_elapsed >= m_acc - 1) && wait_hist[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_elapsed = 0; m_beat = 0; m_ph = 0;
      wait_hist = '{1'b1, 1'b1};
    end else begin
      bit d;
      d = m_done_f();
      if (m_busy) begin
        if (d) begin
          if (m_beat == m_beats - 1) m_busy = 0;
          else begin m_elapsed = 0; m_beat++; end
        end else if (m_elapsed < m_acc - 1) m_elapsed++;
        m_ph = (m_ph + 1) % (m_div + 1);
      end else if (start_i) begin
        int a, p, b;
        a = int'(acc_cycles_i); p = int'(div_sel_i) + 1; b = int'(beat_num_i);
        if (a != 0 && b != 0 && (a % p) == 0) begin
          m_busy = 1; m_err = 0; m_elapsed = 0; m_beat = 0; m_ph = 0;
          m_acc = a; m_beats = b; m_div = p - 1;
        end else m_err = 1;
      end
      void'(wait_hist.pop_front());
      wait_hist.push_back(wait_n_i);
    end
  end

  // Per-cycle comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit md;
      md = m_done_f();
      chk("R2 busy", busy_o, m_busy);
      chk("R3 cfg_err", cfg_err_o, m_err);
      chk("R4 beat_done", beat_done_o, md);
      chk("R8 last_beat", last_beat_o, md && (m_beat == m_beats - 1));
      chk("R9 clk_en", ext_clk_en_o, m_busy && m_ph == 0);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic launch(input int div, input int acc, input int beats);
    div_sel_i = 2'(div); acc_cycles_i = ACC_W'(acc); beat_num_i = BEAT_W'(beats);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_out(output int nbeats, output int nticks);
    nbeats = 0; nticks = 0;
    for (int g = 0; g < 2000 && busy_o; g++) begin
      nbeats += beat_done_o;
      nticks += ext_clk_en_o;
      @(negedge clk);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    int nb, nt, hold_done;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 cfg_err", cfg_err_o, 0);
    chk("R1 done", beat_done_o | last_beat_o | ext_clk_en_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Basic run, div 0
    launch(0, 3, 4);
    chk("R2 busy after start", busy_o, 1);
    run_out(nb, nt);
    chk("R4 beat count", nb, 4);
    chk("R9 tick count div0", nt, 12);

    // Wait stall on second beat
    launch(1, 4, 3);
    for (int g = 0; g < 50 && !beat_done_o; g++) @(negedge clk);
    wait_n_i = 1'b0;
    @(negedge clk);
    hold_done = 0;
    for (int g = 0; g < 12; g++) begin
      hold_done += beat_done_o;
      @(negedge clk);
    end
    chk("R7 no beat while wait held", hold_done, 0);
    chk("R5 still busy under wait", busy_o, 1);
    wait_n_i = 1'b1;
    @(negedge clk);
    chk("R6 one edge after release", beat_done_o, 0);
    @(negedge clk);
    chk("R6 two edges after release", beat_done_o, 1);
    run_out(nb, nt);

    // Rejected launches
    launch(2, 4, 2);
    chk("R3 non-multiple sets err", cfg_err_o, 1);
    chk("R3 non-multiple no busy", busy_o, 0);
    launch(0, 0, 2);
    chk("R3 zero access rejected", cfg_err_o, 1);
    launch(0, 2, 0);
    chk("R3 zero beats rejected", busy_o, 0);

    // Accepted launch clears error; mid-cycle start ignored
    launch(2, 6, 2);
    chk("R3 err cleared", cfg_err_o, 0);
    nb = beat_done_o;
    @(negedge clk);
    launch(0, 1, 9);
    nb += 0;
    run_out(nt, hold_done);
    chk("R10 beats unchanged by mid start", nt, 2);

    // Single beat, div 3: enables at cycle 0 and 4
    launch(3, 8, 1);
    run_out(nb, nt);
    chk("R8 single beat", nb, 1);
    chk("R9 tick count div3", nt, 2);

    // One-cycle beats
    launch(0, 1, 5);
    run_out(nb, nt);
    chk("R4 one-cycle beats", nb, 5);

    // Randomised runs with toggling wait, checked by the model
    for (int r = 0; r < 40; r++) begin
      int d, a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = int'(lfsr[1:0]);
      a = (int'(lfsr[3:2]) + 1) * (d + 1);
      b = int'(lfsr[6:4]) + 1;
      launch(d, a, b);
      for (int g = 0; g < 2000 && busy_o; g++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wait_n_i = lfsr[0] | lfsr[1];
        @(negedge clk);
      end
      wait_n_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 random run ended", busy_o, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule